// File: doc/BRIEF.md
# Armed Edge Timestamp Capture

This block records when each rising edge of a measured signal arrives, as a count of timebase clock cycles since a start trigger. The start trigger is the same one that starts the other acquisition channels, so every timestamp shares their time origin. Before the trigger the block neither counts nor captures. After the trigger a free-running counter advances on every timebase cycle. Each rising edge of the measured signal, once it has passed through a two-flop synchroniser, latches that counter.

Each latched value carries a small wrap tag: the low bits of the number of times the counter has wrapped. Downstream logic or software can then rebuild absolute time past the counter's range. Entries are queued in a 16-entry FIFO and leave on a valid/ready stream. An edge that finds the FIFO full is dropped, and a sticky overflow flag is raised.

The control state machine has two states. `ST_IDLE` is entered on reset: the counter and wrap count are held at zero and no edge is captured. The transition `ST_IDLE -> ST_ARMED` is taken when `start_trig` is seen high. `ST_ARMED` holds until reset, with no transition out on any other input, so a later trigger changes nothing. Converting timestamps into frequencies is left to a later stage.

Top module: `edge_stamp_capture`

## Requirements
- R1: After reset `out_valid` is 0, `overflow` is 0 and the block is in `ST_IDLE`.
- R2: Rising edges of `meas_in` that are sampled before the clock edge at which `start_trig` is first sampled high produce no FIFO entry.
- R3: For an edge first sampled high at clock edge E, with the trigger sampled at edge T0 (E >= T0), `out_stamp` is (E - T0) mod 2^CNT_W. The first edge after arming is kept, and an edge sampled at T0 itself gives stamp 0.
- R4: With the FIFO empty, `out_valid` is still 0 after edge E+1 and is 1 after edge E+2. This is the two-cycle synchroniser latency, and the stamp is corrected for it.
- R5: Only a low-to-high transition is captured. Holding `meas_in` high for many cycles, or a falling edge, gives exactly one entry per rising edge.
- R6: `out_wrap_tag` equals floor((E - T0) / 2^CNT_W) mod 2^TAG_W, so it is consistent with the stamp across a counter wrap.
- R7: Entries leave in capture order. While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_stamp` and `out_wrap_tag` hold steady. Up to 16 entries are held.
- R8: An edge captured while the FIFO holds 16 entries is dropped and the 16 stored entries are unchanged. `overflow` rises two edges after that edge is sampled and stays 1 until reset.
- R9: A `start_trig` pulse while in `ST_ARMED` is ignored. Later stamps stay referenced to the first trigger.
- R10: An entry is removed on each clock edge where `out_valid` and `out_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock (nominally 100 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_trig | input | 1 | Arms the block; synchronous to `clk` |
| meas_in | input | 1 | Measured signal, asynchronous |
| out_ready | input | 1 | Downstream can accept an entry |
| out_stamp | output | CNT_W | Edge time in cycles since the trigger |
| out_wrap_tag | output | TAG_W | Low bits of the wrap count for this stamp |
| out_valid | output | 1 | An entry is presented |
| overflow | output | 1 | Sticky: an edge was dropped on a full FIFO |

## Verification
An edge of `meas_in` first sampled at clock edge E is pushed into the FIFO at edge E+2. It therefore shows on `out_valid` two edges after sampling when the queue is empty, and `overflow` rises at that same edge E+2 when the queue is full. The bench changes inputs a little after each rising edge and reads outputs at the falling edge. It records E and the trigger edge T0 from its own cycle counter, so every expected stamp and tag is (E - T0) split at the counter width. The latency test reads `out_valid` at the falling edges after E+1 and after E+2. The overflow test reads `overflow` only after the edge at which the seventeenth capture is due.

// File: rtl/esc_pkg.sv
package esc_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } arm_state_e;

endpackage

// File: rtl/esc_edge_sync.sv
module esc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic meas_in,
    input  logic armed_in,
    output logic rise_armed
);
    localparam int ARM_DLY = STAGES - 1;

    logic [STAGES-1:0]  sync_q;
    logic               last_q;
    logic [ARM_DLY-1:0] arm_pipe;

    // Synchroniser chain, previous-level flop and armed delay line.
    // The delay line lines the armed state up with the sample that is
    // leaving the chain, so only edges sampled while armed count.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q   <= '0;
            last_q   <= 1'b0;
            arm_pipe <= '0;
        end else begin
            sync_q[0] <= meas_in;
            for (int i = 1; i < STAGES; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
            last_q      <= sync_q[STAGES-1];
            arm_pipe[0] <= armed_in;
            for (int j = 1; j < ARM_DLY; j++) begin
                arm_pipe[j] <= arm_pipe[j-1];
            end
        end
    end

    always_comb begin
        rise_armed = sync_q[STAGES-1] & ~last_q & arm_pipe[ARM_DLY-1];
    end

    // A detected rise lasts one cycle: the level must drop before the next one.
    assert_single_rise_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        rise_armed |=> !rise_armed);

endmodule

// File: rtl/esc_arm_fsm.sv
module esc_arm_fsm
    import esc_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_trig,
    output logic             armed,
    output logic [CNT_W-1:0] cnt,
    output logic [TAG_W-1:0] wrap_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    arm_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_trig) state_d = ST_ARMED;
            ST_ARMED: state_d = ST_ARMED;
        endcase
    end

    // Outputs
    always_comb begin
        armed = 1'b0;
        unique case (state_q)
            ST_IDLE:  armed = 1'b0;
            ST_ARMED: armed = 1'b1;
        endcase
    end

    // Timebase counter and wrap counter, running only while armed
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            wrap_cnt <= '0;
        end else if (armed) begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_MAX) begin
                wrap_cnt <= wrap_cnt + 1'b1;
            end
        end
    end

    // A repeated trigger neither disarms nor restarts the count.
    assert_retrigger_ignored_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        (armed && start_trig) |=> (armed && cnt == CNT_W'($past(cnt) + 1'b1)));

endmodule

// File: rtl/esc_stamp_fifo.sv
module esc_stamp_fifo #(
    parameter int W     = 36,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         out_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_C  = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    always_comb begin
        full      = (count == DEPTH_C);
        out_valid = (count != '0);
        out_data  = mem[rd_ptr];
        do_push   = push && !full;
        do_pop    = out_valid && out_ready;
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST_C) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST_C) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_out_hold_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_fill_bound_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        count <= DEPTH_C);

    assert_full_drop_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !out_ready) |=> (full && $stable(out_data)));

endmodule

// File: rtl/edge_stamp_capture.sv
module edge_stamp_capture
    import esc_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int TAG_W       = 4,
    parameter int FIFO_DEPTH  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_trig,
    input  logic             meas_in,
    input  logic             out_ready,
    output logic [CNT_W-1:0] out_stamp,
    output logic [TAG_W-1:0] out_wrap_tag,
    output logic             out_valid,
    output logic             overflow
);
    // The pre-update count at the capture edge runs ahead of the
    // sampling edge by SYNC_STAGES-1 cycles.
    localparam int               LAT_ADJ = SYNC_STAGES - 1;
    localparam int               ENTRY_W = CNT_W + TAG_W;
    localparam logic [CNT_W-1:0] ADJ_C   = CNT_W'(LAT_ADJ);

    logic               armed;
    logic [CNT_W-1:0]   cnt;
    logic [TAG_W-1:0]   wrap_cnt;
    logic               rise_armed;
    logic               fifo_full;
    logic [CNT_W-1:0]   cap_stamp;
    logic [TAG_W-1:0]   cap_tag;
    logic [ENTRY_W-1:0] cap_entry;
    logic [ENTRY_W-1:0] head_entry;

    esc_arm_fsm #(
        .CNT_W (CNT_W),
        .TAG_W (TAG_W)
    ) arm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_trig (start_trig),
        .armed      (armed),
        .cnt        (cnt),
        .wrap_cnt   (wrap_cnt)
    );

    esc_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .meas_in    (meas_in),
        .armed_in   (armed),
        .rise_armed (rise_armed)
    );

    // Latency correction; if it borrows across a wrap, the stamp
    // belongs to the previous wrap period.
    always_comb begin
        cap_stamp = cnt - ADJ_C;
        cap_tag   = (cnt < ADJ_C) ? wrap_cnt - 1'b1 : wrap_cnt;
        cap_entry = {cap_tag, cap_stamp};
    end

    esc_stamp_fifo #(
        .W     (ENTRY_W),
        .DEPTH (FIFO_DEPTH)
    ) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rise_armed),
        .push_data (cap_entry),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (head_entry),
        .full      (fifo_full)
    );

    always_comb begin
        out_stamp    = head_entry[CNT_W-1:0];
        out_wrap_tag = head_entry[ENTRY_W-1:CNT_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overflow <= 1'b0;
        end else if (rise_armed && fifo_full) begin
            overflow <= 1'b1;
        end
    end

    assert_capture_needs_arm_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        rise_armed |-> armed);

    assert_overflow_sticky_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    assert_no_overflow_unfull_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        (!overflow && !fifo_full) |=> !overflow);

endmodule

// File: tb/edge_stamp_capture_tb.sv
module edge_stamp_capture_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;
    localparam int TW = 4;
    localparam int NVEC = 10;
    // Each row: cycles high, cycles low for one pulse of meas_in.
    localparam int PULSES [NVEC][2] = '{
        '{1, 1}, '{1, 2}, '{3, 1}, '{2, 40}, '{5, 120},
        '{1, 250}, '{2, 3}, '{1, 260}, '{4, 9}, '{1, 1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_trig = 1'b0;
    logic          meas_in = 1'b0;
    logic          out_ready = 1'b0;
    logic [CW-1:0] out_stamp;
    logic [TW-1:0] out_wrap_tag;
    logic          out_valid;
    logic          overflow;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int t0 = 0;
    bit done = 0;
    logic [CW+TW-1:0] exp_q [$];

    edge_stamp_capture #(
        .CNT_W (CW), .TAG_W (TW), .FIFO_DEPTH (16), .SYNC_STAGES (2)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .start_trig (start_trig), .meas_in (meas_in),
        .out_ready (out_ready), .out_stamp (out_stamp), .out_wrap_tag (out_wrap_tag),
        .out_valid (out_valid), .overflow (overflow)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    // One pulse; E is the next rising edge, which first samples it high.
    task automatic pulse(input int hi, input int lo, input bit store);
        int e;
        meas_in = 1'b1;
        e = cyc + 1;
        if (store) exp_q.push_back({TW'((e - t0) >> CW), CW'(e - t0)});
        step(hi);
        meas_in = 1'b0;
        step(lo);
    endtask

    // Monitor: every accepted entry must match the next expected one (R3, R6, R7, R10)
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "unexpected entry stamp", out_stamp, 0);
            end else begin
                check(out_stamp == exp_q[0][CW-1:0], "R3", "stamp",
                      out_stamp, exp_q[0][CW-1:0]);
                check(out_wrap_tag == exp_q[0][CW+TW-1:CW], "R6", "wrap tag",
                      out_wrap_tag, exp_q[0][CW+TW-1:CW]);
                void'(exp_q.pop_front());
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] held;
        int e;
        step(3);
        // R1: reset state
        check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        check(overflow == 1'b0, "R1", "overflow in reset", overflow, 0);
        rst_n = 1'b1;
        out_ready = 1'b1;
        step(2);

        // R2: edges before the trigger are not captured
        for (int i = 0; i < 4; i++) pulse(1, 2, 1'b0);
        step(4);
        check(out_valid == 1'b0, "R2", "valid before trigger", out_valid, 0);

        // R3: trigger and an edge sampled at the same clock edge -> stamp 0
        start_trig = 1'b1;
        t0 = cyc + 1;
        pulse(1, 3, 1'b1);
        start_trig = 1'b0;

        // Table walk: varied pulse shapes, spanning counter wraps (R3, R6)
        for (int v = 0; v < NVEC; v++) pulse(PULSES[v][0], PULSES[v][1], 1'b1);
        step(4);
        check(exp_q.size() == 0, "R3", "entries left after table", exp_q.size(), 0);

        // R4: latency through the synchroniser
        meas_in = 1'b1;
        e = cyc + 1;
        exp_q.push_back({TW'((e - t0) >> CW), CW'(e - t0)});
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R4", "valid after E+1", out_valid, 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R4", "valid after E+2", out_valid, 1);
        meas_in = 1'b0;
        step(4);

        // R5: a long high level gives exactly one entry
        pulse(20, 5, 1'b1);
        check(exp_q.size() == 0, "R5", "pending after long high", exp_q.size(), 0);
        check(out_valid == 1'b0, "R5", "valid after long high", out_valid, 0);

        // R7, R8: fill with ready low, then overflow
        out_ready = 1'b0;
        for (int i = 0; i < 16; i++) pulse(1, 2, 1'b1);
        check(overflow == 1'b0, "R8", "overflow at 16 entries", overflow, 0);
        held = out_stamp;
        check(out_stamp == exp_q[0][CW-1:0], "R7", "head while stalled",
              out_stamp, exp_q[0][CW-1:0]);
        pulse(1, 2, 1'b0);
        check(overflow == 1'b1, "R8", "overflow after 17th edge", overflow, 1);
        check(out_valid == 1'b1 && out_stamp == held, "R7", "head held",
              out_stamp, held);
        out_ready = 1'b1;
        step(20);
        check(exp_q.size() == 0, "R10", "drained entries left", exp_q.size(), 0);
        check(overflow == 1'b1, "R8", "overflow sticky", overflow, 1);

        // R9: a second trigger keeps the original time origin
        start_trig = 1'b1;
        step(1);
        start_trig = 1'b0;
        step(5);
        pulse(1, 4, 1'b1);
        step(2);
        check(exp_q.size() == 0, "R9", "entry after retrigger", exp_q.size(), 0);

        // R1: reset clears the overflow flag
        rst_n = 1'b0;
        step(1);
        check(overflow == 1'b0, "R1", "overflow after reset", overflow, 0);
        check(out_valid == 1'b0, "R1", "valid after reset", out_valid, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule